// File: doc/BRIEF.md
# Interrupting General-Purpose Pin Controller

This block is a register-mapped controller for up to 32 general-purpose pins. Each pin is either an input or an output, and software sets the direction one pin at a time. An output pin is driven from a latch that software writes. Reading the value register returns what each pin is doing right now. Input pins pass through a synchroniser before the rest of the block uses them.

Every pin has its own trigger detector. A mode bit chooses between level triggering and single-edge triggering, and a polarity bit picks which level or which edge counts. A detected trigger sets a raw status bit. The status bit is masked with a per-pin enable to form a pending bit, and all pending bits are ORed onto a single interrupt line. Software acknowledges by writing ones to a clear register.

Access goes through a plain register port: one write strobe, a 3-bit word index (byte offset divided by four), write data and combinational read data.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the direction register holds all ones (every pin an input, `pin_oe` all zero). The enable, mode, polarity and output-latch registers hold zero, and `irq` is low.
- R2: Direction (word 1): a bit of 1 makes that pin an input and releases its drive. A bit of 0 makes it an output: `pin_oe` goes high and `pin_out` carries the output-latch bit.
- R3: Value (word 0): a write loads the output latch. A read returns, per pin, the synchronised `pin_in` level for an input pin and the latch bit for an output pin. A change on `pin_in` reaches the synchronised level after `SYNC_STAGES` clocks (two by default).
- R4: Level mode (mode bit 0 in word 6). A polarity bit of 1 in word 7 triggers while the pin is high; 0 triggers while it is low. The status bit stays set until it is cleared. A clear is applied even if the level still holds, and the bit comes back on the following cycle.
- R5: Edge mode (mode bit 1). Polarity 0 triggers on a rising edge and 1 on a falling edge; only one edge per pin can be selected. An edge is detected by comparing the synchronised level with its value one clock earlier. The status bit holds until it is cleared. An edge that arrives in the same cycle as a clear survives that clear.
- R6: Status (word 3) shows the raw trigger events whatever the enable bits say. Writes to it are ignored.
- R7: Clear (word 5): writing a 1 clears that pin's status bit, and writing a 0 leaves it unchanged. The register reads as zero.
- R8: Pending (word 4) reads as status AND enable (word 2).
- R9: `irq` is high exactly when at least one pending bit is set.
- R10: Register bits at or above `NPINS` read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_word | input | 3 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_word`, combinational |
| pin_in | input | NPINS | Pin levels seen at the pads |
| pin_out | output | NPINS | Output latch driven toward the pads |
| pin_oe | output | NPINS | Per-pin output enable (1 = drive) |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with `NPINS` = 8 and the default two-stage synchroniser. With 8 pins, the upper 24 bits of every register are unimplemented, so writing all ones to them and reading back zeros is a real test. With only 8 pins, one run can split the pins between level and edge mode, and between input and output, with every pin's expected value written out by hand. The default synchroniser depth fixes the delay from a pin change to a status change at three clocks, which the bench waits out before each read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int unsigned BUS_W  = 32;
   localparam int unsigned WORD_W = 3;

   // Word index of each register on the port (byte offset / 4).
   typedef enum logic [WORD_W-1:0] {
      RG_VALUE   = 3'd0,
      RG_DIR     = 3'd1,
      RG_ENABLE  = 3'd2,
      RG_STATUS  = 3'd3,
      RG_PENDING = 3'd4,
      RG_CLEAR   = 3'd5,
      RG_MODE    = 3'd6,
      RG_POL     = 3'd7
   } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);
   if (STAGES > 4) begin : g_bad_depth
      $error("gpio_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_bypass
      assign d_out = d_in;
   end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= d_in;
            else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
      assign d_out = stage_q[STAGES-1];
   end
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] mode,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] clr,
   output logic [W-1:0] status
);
   logic [W-1:0] prev_q;
   logic [W-1:0] rise, fall;
   logic [W-1:0] edge_hit, level_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else prev_q <= lvl;
   end

   assign rise      = lvl & ~prev_q;
   assign fall      = ~lvl & prev_q;
   assign edge_hit  = mode & ((pol & fall) | (~pol & rise));
   assign level_hit = ~mode & ((pol & lvl) | (~pol & ~lvl));

   // Level set loses to a clear; edge set beats it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else status <= edge_hit | ((level_hit | status) & ~clr);
   end

   p_level_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & $past(clr & ~mode)) == '0));

   p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(status) & $past(mode) & ~$past(clr)) & ~status) == '0));

   p_edge_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(edge_hit) & ~status) == '0));

   p_edge_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((edge_hit & pol) != '0) |-> ((prev_q & ~lvl) != '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPINS       = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [WORD_W-1:0] bus_word,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq
);
   if (NPINS < 1 || NPINS > BUS_W) begin : g_bad_pins
      $error("gpio_irq_ctrl: NPINS must be 1..32");
   end

   localparam int unsigned PW = NPINS;

   logic [PW-1:0] out_q, dir_q, ien_q, mode_q, pol_q;
   logic [PW-1:0] sync_lvl, status, pending, clr_vec, wbits;
   gpio_reg_e     wsel;

   assign wsel  = gpio_reg_e'(bus_word);
   assign wbits = bus_wdata[PW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '1;
         ien_q  <= '0;
         mode_q <= '0;
         pol_q  <= '0;
      end else if (bus_wr) begin
         case (wsel)
            RG_VALUE:  out_q  <= wbits;
            RG_DIR:    dir_q  <= wbits;
            RG_ENABLE: ien_q  <= wbits;
            RG_MODE:   mode_q <= wbits;
            RG_POL:    pol_q  <= wbits;
            default: ;
         endcase
      end
   end

   assign clr_vec = (bus_wr && wsel == RG_CLEAR) ? wbits : '0;

   gpio_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_in (pin_in),
      .d_out(sync_lvl)
   );

   gpio_trig #(.W(PW)) u_trig (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (sync_lvl),
      .mode  (mode_q),
      .pol   (pol_q),
      .clr   (clr_vec),
      .status(status)
   );

   assign pending = status & ien_q;
   assign irq     = |pending;
   assign pin_out = out_q;
   assign pin_oe  = ~dir_q;

   always_comb begin
      bus_rdata = '0;
      case (wsel)
         RG_VALUE:   bus_rdata[PW-1:0] = (dir_q & sync_lvl) | (~dir_q & out_q);
         RG_DIR:     bus_rdata[PW-1:0] = dir_q;
         RG_ENABLE:  bus_rdata[PW-1:0] = ien_q;
         RG_STATUS:  bus_rdata[PW-1:0] = status;
         RG_PENDING: bus_rdata[PW-1:0] = pending;
         RG_MODE:    bus_rdata[PW-1:0] = mode_q;
         RG_POL:     bus_rdata[PW-1:0] = pol_q;
         default:    bus_rdata = '0;
      endcase
   end

   p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ien_q != '0));

   p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && wsel == RG_DIR) |=> (pin_oe == ~$past(bus_wdata[PW-1:0])));

   p_enable_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && wsel == RG_ENABLE) |=> ((pending & ~$past(bus_wdata[PW-1:0])) == '0));
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
   localparam int unsigned NP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_word = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   gpio_irq_ctrl #(.NPINS(NP), .SYNC_STAGES(2)) u_gpio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   typedef struct packed {
      logic        wr;
      logic [2:0]  word;
      logic [31:0] data;
      logic [7:0]  pins;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 33;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 3'd7, 32'h00, 8'h00, 4'd4},       // R4 low-level on all pins
      '{1'b0, 3'd3, 32'hFF, 8'h00, 4'd6},       // R6 raw status without enable
      '{1'b0, 3'd4, 32'h00, 8'h00, 4'd8},       // R8
      '{1'b1, 3'd6, 32'hF0, 8'h00, 4'd5},       // upper pins edge
      '{1'b1, 3'd5, 32'hFF, 8'h00, 4'd7},
      '{1'b0, 3'd3, 32'h0F, 8'h00, 4'd4},       // R4 level re-sets, R5 edge stays clear
      '{1'b1, 3'd7, 32'h0F, 8'h00, 4'd4},
      '{1'b1, 3'd5, 32'hFF, 8'h00, 4'd7},
      '{1'b0, 3'd3, 32'h00, 8'h00, 4'd4},
      '{1'b1, 3'd0, 32'hAA, 8'h00, 4'd3},       // R3 latch write
      '{1'b0, 3'd0, 32'h00, 8'h00, 4'd3},       // inputs read pins
      '{1'b1, 3'd1, 32'h0F, 8'h00, 4'd2},       // R2 upper pins outputs
      '{1'b0, 3'd0, 32'hA0, 8'h00, 4'd2},
      '{1'b0, 3'd0, 32'hA5, 8'h05, 4'd3},
      '{1'b1, 3'd5, 32'hFF, 8'h00, 4'd4},
      '{1'b0, 3'd3, 32'h00, 8'h00, 4'd4},
      '{1'b1, 3'd2, 32'h30, 8'h00, 4'd8},
      '{1'b0, 3'd3, 32'h10, 8'h10, 4'd5},       // R5 rising edge on pin 4
      '{1'b0, 3'd4, 32'h10, 8'h10, 4'd8},
      '{1'b0, 3'd3, 32'h10, 8'h00, 4'd5},       // falling ignored, bit holds
      '{1'b1, 3'd5, 32'h00, 8'h00, 4'd7},       // R7 zero write
      '{1'b0, 3'd3, 32'h10, 8'h00, 4'd7},
      '{1'b1, 3'd5, 32'h10, 8'h00, 4'd7},
      '{1'b0, 3'd4, 32'h00, 8'h00, 4'd8},
      '{1'b1, 3'd7, 32'h8F, 8'h00, 4'd5},       // pin 7 falling
      '{1'b0, 3'd3, 32'h00, 8'h80, 4'd5},
      '{1'b0, 3'd3, 32'h80, 8'h00, 4'd5},
      '{1'b0, 3'd5, 32'h00, 8'h00, 4'd7},       // clear reads zero
      '{1'b1, 3'd1, 32'hFFFFFF0F, 8'h00, 4'd10},// R10 upper bits dropped
      '{1'b0, 3'd1, 32'h0F, 8'h00, 4'd10},
      '{1'b0, 3'd2, 32'h30, 8'h00, 4'd10},
      '{1'b0, 3'd6, 32'hF0, 8'h00, 4'd10},
      '{1'b0, 3'd7, 32'h8F, 8'h00, 4'd10}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] w, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_word = w; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_reg(input logic [2:0] w, output logic [31:0] d);
      @(negedge clk);
      bus_word = w;
      #1 d = bus_rdata;
   endtask

   initial begin
      logic [31:0] rv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 pin_oe", 32'(pin_oe), 32'h0);
      check("R1 pin_out", 32'(pin_out), 32'h0);
      check("R1 irq", 32'(irq), 32'h0);
      rd_reg(3'd1, rv); check("R1 dir", rv, 32'hFF);
      rd_reg(3'd2, rv); check("R1 enable", rv, 32'h0);
      rd_reg(3'd6, rv); check("R1 mode", rv, 32'h0);

      for (int i = 0; i < NV; i++) begin
         pin_in = VEC[i].pins;
         repeat (4) @(negedge clk);
         if (VEC[i].wr) begin
            wr_reg(VEC[i].word, VEC[i].data);
         end else begin
            rd_reg(VEC[i].word, rv);
            check($sformatf("R%0d vec%0d", VEC[i].req, i), rv, VEC[i].data);
         end
      end

      // R2 pad drive after direction 0x0F and latch 0xAA
      check("R2 pin_oe", 32'(pin_oe), 32'hF0);
      check("R2 pin_out", 32'(pin_out[7:4]), 32'hA);
      // R9 combined line: status 0x80, enable 0x30
      check("R9 irq masked", 32'(irq), 32'h0);
      wr_reg(3'd2, 32'h80);
      check("R9 irq raised", 32'(irq), 32'h1);
      wr_reg(3'd3, 32'h00); // R6 status write ignored
      rd_reg(3'd3, rv); check("R6 status write ignored", rv, 32'h80);
      wr_reg(3'd5, 32'h80);
      check("R9 irq after clear", 32'(irq), 32'h0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule